// File: doc/BRIEF.md
# Half-Word Masked GPIO Port Register Bank

This block is the register front end of a 32-pin general-purpose I/O bank on a simple single-cycle memory-mapped bus. It holds the value driven onto each pin and whether that pin drives at all. It also offers a synchronised view of the external pin levels and a fixed identification word.

The output-value and drive-enable registers are each split across two adjacent word addresses. The word at the register's base address covers pins 0 to 15, and the word at base+4 covers pins 16 to 31. Every write to one of these words carries its own write mask in bits 31:16. Data bit i changes only when bit i+16 of the same word is 1. Software can therefore flip one pin without first reading the register, and two agents that touch different pins cannot overwrite each other's bits.

Reads take effect in the same cycle: `bus_rdata` follows `bus_addr` combinationally. Writes take effect at the clock edge on which `bus_sel` and `bus_wr` are both high.

Top module: `gpio_mw_bank`

## Requirements
- R1: After reset, `pin_out` and `pin_oe` are all zero, so every pin starts as an input that drives low.
- R2: A write to offset 0x00 updates `pin_out[i]` (i = 0..15) to `bus_wdata[i]` only where `bus_wdata[i+16]` is 1. Every other bit of `pin_out` keeps its value.
- R3: A write to offset 0x04 updates `pin_out[16+i]` (i = 0..15) to `bus_wdata[i]` only where `bus_wdata[i+16]` is 1. Every other bit of `pin_out` keeps its value.
- R4: A write whose bits 31:16 are 0xFFFF loads all 16 data bits of the addressed half at once. A write whose bits 31:16 are 0x0000 changes nothing.
- R5: Offsets 0x08 (pins 0..15) and 0x0C (pins 16..31) hold the drive enables with the same masked-write rule. A bit of 1 drives `pin_oe` high (output), and 0 makes the pin an input.
- R6: A read of 0x00, 0x04, 0x08 or 0x0C returns the 16 stored bits of that half in bits 15:0 and zero in bits 31:16.
- R7: A read of 0x70 returns `pin_in` through a two-flop synchroniser. A change on `pin_in` becomes visible after exactly two rising clock edges.
- R8: A read of 0x78 returns the constant 0x01000C2B.
- R9: A write to any offset other than 0x00, 0x04, 0x08 and 0x0C leaves `pin_out` and `pin_oe` unchanged. A read of any offset other than 0x00, 0x04, 0x08, 0x0C, 0x70 and 0x78 returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write word: mask in 31:16, data in 15:0 for split registers |
| bus_rdata | output | 32 | Read word, combinational from the address |
| pin_in | input | 32 | Asynchronous external pin levels |
| pin_out | output | 32 | Value driven on each pin |
| pin_oe | output | 32 | Per-pin drive enable, 1 = output |

## Verification
Several properties are checked on every clock cycle:
- a write with an all-zero mask, or to an offset outside the split registers, leaves the pin outputs and enables untouched;
- a full-mask write loads its half exactly;
- the pin readback trails `pin_in` by two cycles;
- the upper half of every split-register read is zero.

Only the bench's scenarios can show the remaining behaviour. These are the bit-by-bit merging of partial masks across long random write sequences, the separation between the output and enable registers, and the value of each register after reset. They also cover the zero returned from unmapped reads and the fixed identification word.

// File: rtl/gpio_mw_bank.sv
module gpio_mw_bank #(
  parameter int          NPINS   = 32,
  parameter int          AW      = 8,
  parameter logic [31:0] VERSION = 32'h01000C2B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe
);
  localparam int HW     = 16;
  localparam int HALVES = NPINS / HW;

  localparam logic [AW-1:0] OFF_OUT = AW'(8'h00);
  localparam logic [AW-1:0] OFF_DIR = AW'(8'h08);
  localparam logic [AW-1:0] OFF_EXT = AW'(8'h70);
  localparam logic [AW-1:0] OFF_VER = AW'(8'h78);

  logic [NPINS-1:0] out_q, dir_q, sync1_q, sync2_q;
  logic             wen;

  assign wen     = bus_sel && bus_wr;
  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic [AW-1:0] a_out, a_dir;
    logic [HW-1:0] msk, dat;
    assign a_out = OFF_OUT + AW'(4 * h);
    assign a_dir = OFF_DIR + AW'(4 * h);
    assign msk   = bus_wdata[31:16];
    assign dat   = bus_wdata[15:0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_q[h*HW +: HW] <= '0;
        dir_q[h*HW +: HW] <= '0;
      end else if (wen) begin
        if (bus_addr == a_out)
          out_q[h*HW +: HW] <= (out_q[h*HW +: HW] & ~msk) | (dat & msk);
        if (bus_addr == a_dir)
          dir_q[h*HW +: HW] <= (dir_q[h*HW +: HW] & ~msk) | (dat & msk);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int h = 0; h < HALVES; h++) begin
      if (bus_addr == OFF_OUT + AW'(4 * h)) bus_rdata = {16'h0, out_q[h*HW +: HW]};
      if (bus_addr == OFF_DIR + AW'(4 * h)) bus_rdata = {16'h0, dir_q[h*HW +: HW]};
    end
    if (bus_addr == OFF_EXT) bus_rdata = 32'(sync2_q);
    if (bus_addr == OFF_VER) bus_rdata = VERSION;
  end

  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  logic split_hit;
  assign split_hit = (bus_addr == 8'h00) || (bus_addr == 8'h04) ||
                     (bus_addr == 8'h08) || (bus_addr == 8'h0C);

  assert_unmapped_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && !split_hit) |=> ($stable(pin_out) && $stable(pin_oe)));

  assert_empty_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && bus_wdata[31:16] == 16'h0) |=> ($stable(pin_out) && $stable(pin_oe)));

  assert_full_mask_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && bus_addr == 8'h00 && bus_wdata[31:16] == 16'hFFFF)
      |=> (pin_out[15:0] == $past(bus_wdata[15:0])));

  assert_full_mask_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && bus_addr == 8'h04 && bus_wdata[31:16] == 16'hFFFF)
      |=> (pin_out[31:16] == $past(bus_wdata[15:0])));

  assert_dir_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && bus_addr == 8'h08 && bus_wdata[31:16] == 16'hFFFF)
      |=> (pin_oe[15:0] == $past(bus_wdata[15:0])));

  assert_split_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    split_hit |-> (bus_rdata[31:16] == 16'h0));

  assert_sync_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2 && bus_addr == 8'h70) |-> (bus_rdata == 32'($past(pin_in, 2))));
endmodule

// File: tb/tb_gpio_mw_bank.sv
module tb_gpio_mw_bank;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [31:0] pin_in = 0, pin_out, pin_oe;

  int tests = 0, fails = 0;
  logic [31:0] m_out = 0, m_dir = 0;

  always #5 clk = ~clk;

  gpio_mw_bank dut (.clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata,
                    .bus_rdata, .pin_in, .pin_out, .pin_oe);

  function automatic logic [15:0] merge(logic [15:0] old, logic [31:0] w);
    return (old & ~w[31:16]) | (w[15:0] & w[31:16]);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    case (a)
      8'h00: m_out[15:0]  = merge(m_out[15:0], d);
      8'h04: m_out[31:16] = merge(m_out[31:16], d);
      8'h08: m_dir[15:0]  = merge(m_dir[15:0], d);
      8'h0C: m_dir[31:16] = merge(m_dir[31:16], d);
      default: ;
    endcase
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 out", pin_out, 32'h0);
    check("R1 oe", pin_oe, 32'h0);

    wr(8'h00, 32'h0001_0001);
    check("R2 single low pin", pin_out, m_out);
    wr(8'h04, 32'h8000_8000);
    check("R3 single high pin", pin_out, 32'h8000_0001);
    wr(8'h00, 32'hFFFF_A5A5);
    check("R4 full mask", pin_out, 32'h8000_A5A5);
    wr(8'h04, 32'h0000_FFFF);
    check("R4 empty mask", pin_out, 32'h8000_A5A5);
    wr(8'h0C, 32'h00F0_00A0);
    check("R5 dir high", pin_oe, 32'h00A0_0000);
    check("R5 out untouched", pin_out, 32'h8000_A5A5);
    rd(8'h00, r); check("R6 read low", r, 32'h0000_A5A5);
    rd(8'h0C, r); check("R6 read dir high", r, 32'h0000_00A0);
    rd(8'h78, r); check("R8 version", r, 32'h01000C2B);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h7C, 32'hFFFF_FFFF);
    check("R9 write ignored out", pin_out, m_out);
    check("R9 write ignored oe", pin_oe, m_dir);
    rd(8'h10, r); check("R9 unmapped read", r, 32'h0);
    rd(8'h02, r); check("R9 misaligned read", r, 32'h0);

    @(negedge clk); pin_in = 32'hDEAD_BEEF; bus_addr = 8'h70;
    @(negedge clk); #1 check("R7 one edge old", bus_rdata, 32'h0);
    @(negedge clk); #1 check("R7 two edges new", bus_rdata, 32'hDEAD_BEEF);

    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      case ($urandom % 6)
        0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08; 3: a = 8'h0C;
        4: a = 8'h40; default: a = 8'hFC;
      endcase
      wr(a, $urandom);
      check("R2 R3 R5 random out", pin_out, m_out);
      check("R5 R9 random oe", pin_oe, m_dir);
      if (i % 8 == 0) begin
        logic [31:0] pv;
        pv = $urandom;
        pin_in = pv;
        rd(8'h04, r); check("R6 random read", r, {16'h0, m_out[31:16]});
        rd(8'h08, r); check("R6 random dir read", r, {16'h0, m_dir[15:0]});
        rd(8'h70, r); check("R7 random pins", r, pv);
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule